// File: doc/BRIEF.md
# Three-Channel Wiper Position Target on a Two-Wire Serial Bus

This block is the serial-bus front end of a three-channel digital potentiometer controller. It oversamples the bus clock and data lines with the system clock and detects start, repeated start and stop conditions. It acknowledges its own device address, takes a memory pointer byte, and then either accepts data bytes or returns them. The block drives the data line only through an open-drain enable: it pulls the line low when the enable is set.

Three position registers hold a 7-bit wiper setting each. The memory pointer persists between transactions and advances after every byte transferred, so current-address reads, random reads (pointer write, repeated start, read) and long sequential reads work as a bus master expects. Each accepted position write updates the wiper output at once. It also raises a one-cycle request towards a nonvolatile commit engine. The commit engine reports back through a busy input, and while that input is high the block ignores its own address, so a master can poll for completion. A lock input refuses all position writes.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: The device byte is received MSB first as the control code 101000, then a select bit, then the direction bit (1 = read). When the code matches and the select bit equals `addr_sel`, the block pulls SDA low for the ninth clock. Memory-pointer and data bytes are acknowledged in the same way.
- R2: If the control code or the select bit differs, the address byte is not acknowledged. Every byte after it, up to the next start, is ignored: it gets no acknowledge and changes no position.
- R3: Pointer F9h selects channel 0, F8h selects channel 1 and FAh selects channel 2. A written byte keeps only its low seven bits, so 82h stores as 02h. After reset all three positions are 7Fh.
- R4: A write to any other pointer value is acknowledged but discarded. A read from any other pointer value returns 00h.
- R5: While `wr_lock` is high, data bytes are still acknowledged, but no position changes and no commit request is raised.
- R6: The pointer holds the last accessed address plus one and keeps that value across stop conditions. A read that starts without a pointer byte returns the byte at the pointer.
- R7: A pointer byte, then a repeated start and a read, returns the byte at that pointer.
- R8: A sequential read continues while the master acknowledges each byte, and the pointer wraps from FFh to 00h. A write of several bytes also advances the pointer after each byte.
- R9: After the master does not acknowledge a read byte, the block releases SDA and stays idle until the next start.
- R10: While `commit_busy` is high, the device address is not acknowledged. Once it is low again, the address is acknowledged.
- R11: A start condition in the middle of any byte abandons that byte and restarts reception of the device address.
- R12: Every accepted position write produces a one-cycle `commit_req`, with `commit_addr` set to the pointer value and `commit_data` set to the stored 7-bit value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Strapped select bit of the device address |
| wr_lock | input | 1 | High refuses position writes |
| commit_busy | input | 1 | Nonvolatile commit in progress |
| pos_ch0 | output | 7 | Wiper position, channel 0 (F9h) |
| pos_ch1 | output | 7 | Wiper position, channel 1 (F8h) |
| pos_ch2 | output | 7 | Wiper position, channel 2 (FAh) |
| commit_req | output | 1 | One-cycle request to store a position |
| commit_addr | output | 8 | Pointer value of the stored position |
| commit_data | output | 8 | Stored position, zero-extended |

## Verification
Most internal faults show up on the bus within one byte. A wrong state or bit count moves the ninth-clock acknowledge, or data bits appear one position off in the next read byte. Pointer faults are different: nothing shows on a single access, because a wrong pointer only appears on the next current-address or sequential read. That read may come many transactions later, and the sequential read of 255 bytes across the wrap is the only test that exposes a pointer which fails to roll over. Faults in the lock and commit paths appear on the position outputs and on `commit_req` within two clocks of the ninth bus clock edge.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;

  localparam logic [5:0] DEV_CODE_DEFAULT = 6'b101000;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  // index 0 = clock line, index 1 = data line
  assign sda_hi    = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign bus_start = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign bus_stop  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import wiper_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [5:0] DEV_CODE = DEV_CODE_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_hi,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_sel,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [DATA_W-1:0] ptr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx;
  logic              rw;
  logic              mack;
  logic              dev_match;
  logic              byte_in;
  logic              byte_end;

  assign dev_match = (shreg[DATA_W-1:2] == DEV_CODE) && (shreg[1] == addr_sel);
  assign byte_in   = scl_rise && (cnt != LAST);
  assign byte_end  = scl_fall && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (bus_start) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV: begin
            if (byte_in) begin
              shreg <= {shreg[DATA_W-2:0], sda_hi};
              cnt   <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              if (dev_match && !busy) begin
                state  <= ST_DEV_ACK;
                sda_oe <= 1'b1;
                rw     <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                state  <= ST_RD;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
              end else begin
                state  <= ST_REG;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_REG: begin
            if (byte_in) begin
              shreg <= {shreg[DATA_W-2:0], sda_hi};
              cnt   <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt    <= '0;
              ptr    <= shreg;
              state  <= ST_REG_ACK;
              sda_oe <= 1'b1;
            end
          end
          ST_WR: begin
            if (byte_in) begin
              shreg <= {shreg[DATA_W-2:0], sda_hi};
              cnt   <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt     <= '0;
              wr_stb  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              ptr     <= ptr + 1'b1;
              state   <= ST_WR_ACK;
              sda_oe  <= 1'b1;
            end
          end
          ST_REG_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              state  <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (byte_in) begin
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_RD_ACK;
            end else if (scl_fall) begin
              tx     <= {tx[DATA_W-2:0], 1'b0};
              sda_oe <= ~tx[DATA_W-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_hi;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RD;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  // R10: a busy commit engine keeps the address unacknowledged
  a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && byte_end && busy) |=> !sda_oe);

  // R2: a foreign address is never acknowledged
  a_r2_mismatch_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && byte_end && !dev_match) |=> (!sda_oe && state == ST_IDLE));

  // R9: master refusal releases the line and idles the target
  a_r9_release_after_nack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_ACK && scl_fall && !mack && !bus_start && !bus_stop)
      |=> (!sda_oe && state == ST_IDLE));

  // R11: any start restarts device address reception
  a_r11_start_restarts: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (state == ST_DEV && cnt == '0 && !sda_oe));

endmodule

// File: rtl/wiper_regs.sv
module wiper_regs #(
  parameter int              NCH       = 3,
  parameter int              POS_W     = 7,
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] BASE    = 8'hF8,
  parameter logic [POS_W-1:0]  RST_POS = 7'h7F
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_stb,
  input  logic [DATA_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      wr_lock,
  input  logic [DATA_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NCH-1:0][POS_W-1:0] pos,
  output logic                      commit_req,
  output logic [DATA_W-1:0]         commit_addr,
  output logic [DATA_W-1:0]         commit_data
);

  // channel 1 sits at the base address, channel 0 one above it
  function automatic logic [DATA_W-1:0] chan_addr(input int k);
    int off;
    off = (k == 0) ? 1 : ((k == 1) ? 0 : k);
    return BASE + DATA_W'(off);
  endfunction

  logic [NCH-1:0] hit;

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    assign hit[k] = wr_stb && !wr_lock && (wr_addr == chan_addr(k));
    always_ff @(posedge clk) begin
      if (rst)         pos[k] <= RST_POS;
      else if (hit[k]) pos[k] <= wr_data[POS_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCH; k++) begin
      if (rd_addr == chan_addr(k)) rd_data = DATA_W'(pos[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_req  <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      commit_req <= |hit;
      if (|hit) begin
        commit_addr <= wr_addr;
        commit_data <= DATA_W'(wr_data[POS_W-1:0]);
      end
    end
  end

  // R5: a locked write leaves every position and the commit path untouched
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_lock) |=> ($stable(pos) && !commit_req));

  // R12: commit requests only name mapped position addresses
  a_r12_commit_in_window: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> (int'(commit_addr) >= int'(BASE) && int'(commit_addr) < int'(BASE) + NCH));

endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wiper_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         POS_W       = 7,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] BASE_ADDR   = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic              wr_lock,
  input  logic              commit_busy,
  output logic [POS_W-1:0]  pos_ch0,
  output logic [POS_W-1:0]  pos_ch1,
  output logic [POS_W-1:0]  pos_ch2,
  output logic              commit_req,
  output logic [DATA_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  localparam int NCH = 3;

  logic sda_hi, scl_rise, scl_fall, bus_start, bus_stop;
  logic [DATA_W-1:0] ptr, rd_data, wr_addr, wr_data;
  logic wr_stb;
  logic [NCH-1:0][POS_W-1:0] pos_q;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_target_fsm #(.DATA_W(DATA_W), .DEV_CODE(DEV_CODE_DEFAULT)) u_fsm (
    .clk(clk), .rst(rst), .sda_hi(sda_hi), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_sel(addr_sel), .busy(commit_busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .ptr(ptr), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  wiper_regs #(.NCH(NCH), .POS_W(POS_W), .DATA_W(DATA_W), .BASE(BASE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_lock(wr_lock), .rd_addr(ptr), .rd_data(rd_data),
    .pos(pos_q), .commit_req(commit_req), .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  assign pos_ch0 = pos_q[0];
  assign pos_ch1 = pos_q[1];
  assign pos_ch2 = pos_q[2];

endmodule

// File: tb/wiper_i2c_ctrl_tb.sv
module wiper_i2c_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst;
  logic scl_m, sda_m;
  logic addr_sel, wr_lock, commit_busy;
  logic sda_oe, commit_req;
  logic [6:0] pos_ch0, pos_ch1, pos_ch2;
  logic [7:0] commit_addr, commit_data;
  logic sda_line;

  int n_checks = 0;
  int n_fail   = 0;
  int commit_cnt = 0;
  logic [7:0] last_caddr, last_cdata;
  logic ack;
  logic [7:0] rbyte;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  wiper_i2c_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .wr_lock(wr_lock), .commit_busy(commit_busy),
    .pos_ch0(pos_ch0), .pos_ch1(pos_ch1), .pos_ch2(pos_ch2),
    .commit_req(commit_req), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always @(posedge clk) begin
    if (!rst && commit_req) begin
      commit_cnt++;
      last_caddr = commit_addr;
      last_cdata = commit_data;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read bytes in arrival order
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  task automatic hwait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hwait();
    scl_m = 1'b1; hwait();
    sda_m = 1'b0; hwait();
    scl_m = 1'b0; hwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hwait();
    scl_m = 1'b1; hwait();
    sda_m = 1'b1; hwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hwait();
    scl_m = 1'b1; hwait();
    scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hwait();
    scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    got_ack = ~sda_line;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hwait();
      scl_m = 1'b1;
      repeat (HALF/2) @(negedge clk);
      v[i] = sda_line;
      repeat (HALF/2) @(negedge clk);
      scl_m = 1'b0;
    end
    send_bit(~master_ack);
    sda_m = 1'b1;
    act_q.push_back(v);
  endtask

  task automatic expect_read(input string req, input logic [7:0] e, input logic master_ack);
    logic [7:0] v;
    exp_q.push_back(e);
    tag_q.push_back(req);
    read_byte(master_ack, v);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base_cnt;
    scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 1'b1; wr_lock = 1'b0; commit_busy = 1'b0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R3: reset positions 7Fh, line released
    check("R3 reset ch0", {1'b0, pos_ch0}, 8'h7F);
    check("R3 reset ch1", {1'b0, pos_ch1}, 8'h7F);
    check("R3 reset ch2", {1'b0, pos_ch2}, 8'h7F);
    check("R9 reset sda", {7'd0, sda_oe}, 8'h00);

    // R1 R3 R12: single write, MSB dropped
    bus_start();
    write_byte(8'hA2, ack); check("R1 addr ack", {7'd0, ack}, 8'h01);
    write_byte(8'hF9, ack); check("R1 ptr ack", {7'd0, ack}, 8'h01);
    write_byte(8'h82, ack); check("R1 data ack", {7'd0, ack}, 8'h01);
    bus_stop();
    check("R3 ch0 82h->02h", {1'b0, pos_ch0}, 8'h02);
    check("R12 commit count", commit_cnt[7:0], 8'd1);
    check("R12 commit addr", last_caddr, 8'hF9);
    check("R12 commit data", last_cdata, 8'h02);

    // R8: multi-byte write advances pointer across channels
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'hF8, ack);
    write_byte(8'h55, ack); write_byte(8'h13, ack); write_byte(8'h7E, ack);
    bus_stop();
    check("R8 ch1", {1'b0, pos_ch1}, 8'h55);
    check("R8 ch0", {1'b0, pos_ch0}, 8'h13);
    check("R8 ch2", {1'b0, pos_ch2}, 8'h7E);
    check("R12 commit count 4", commit_cnt[7:0], 8'd4);

    // R7: random read, then R9 release after NACK
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'hF8, ack);
    bus_start();
    write_byte(8'hA3, ack); check("R7 read addr ack", {7'd0, ack}, 8'h01);
    expect_read("R7 random read F8", 8'h55, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R6: current-address read uses persisted pointer F9h
    bus_start();
    write_byte(8'hA3, ack);
    expect_read("R6 current read", 8'h13, 1'b0);
    bus_stop();

    // R8: sequential read of 255 bytes from FAh, wrapping to F8h
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'hFA, ack);
    bus_start();
    write_byte(8'hA3, ack);
    for (int i = 0; i < 255; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h7E : ((i == 254) ? 8'h55 : 8'h00);
      expect_read("R8 sequential wrap", e, (i != 254));
    end
    bus_stop();
    bus_start();
    write_byte(8'hA3, ack);
    expect_read("R8 pointer after wrap", 8'h13, 1'b0);
    bus_stop();

    // R2: select-bit mismatch and wrong control code
    base_cnt = commit_cnt;
    bus_start();
    write_byte(8'hA0, ack); check("R2 select mismatch nack", {7'd0, ack}, 8'h00);
    write_byte(8'hF9, ack); check("R2 later byte nack", {7'd0, ack}, 8'h00);
    write_byte(8'h44, ack); check("R2 data nack", {7'd0, ack}, 8'h00);
    bus_stop();
    check("R2 ch0 unchanged", {1'b0, pos_ch0}, 8'h13);
    bus_start();
    write_byte(8'hB2, ack); check("R2 code mismatch nack", {7'd0, ack}, 8'h00);
    bus_stop();

    // R5: lock refuses writes but acknowledges
    wr_lock = 1'b1;
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'hF9, ack);
    write_byte(8'h11, ack); check("R5 locked data ack", {7'd0, ack}, 8'h01);
    bus_stop();
    wr_lock = 1'b0;
    check("R5 ch0 unchanged", {1'b0, pos_ch0}, 8'h13);
    check("R5 no commit", commit_cnt[7:0], base_cnt[7:0]);

    // R4: unmapped write acknowledged and discarded, read returns 00h
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'h10, ack);
    write_byte(8'h40, ack); check("R4 unmapped ack", {7'd0, ack}, 8'h01);
    bus_stop();
    check("R4 no commit", commit_cnt[7:0], base_cnt[7:0]);
    check("R4 ch1 unchanged", {1'b0, pos_ch1}, 8'h55);
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'h10, ack);
    bus_start();
    write_byte(8'hA3, ack);
    expect_read("R4 unmapped read", 8'h00, 1'b0);
    bus_stop();

    // R10: busy blocks address ack, released afterwards
    commit_busy = 1'b1;
    bus_start();
    write_byte(8'hA2, ack); check("R10 busy nack", {7'd0, ack}, 8'h00);
    bus_stop();
    commit_busy = 1'b0;
    bus_start();
    write_byte(8'hA2, ack); check("R10 idle ack", {7'd0, ack}, 8'h01);
    write_byte(8'hF8, ack); write_byte(8'h21, ack);
    bus_stop();
    check("R10 write after busy", {1'b0, pos_ch1}, 8'h21);

    // R11: start mid address byte, then mid data byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    write_byte(8'hA2, ack); check("R11 restart ack", {7'd0, ack}, 8'h01);
    write_byte(8'hFA, ack); write_byte(8'h05, ack);
    bus_stop();
    check("R11 ch2 after abort", {1'b0, pos_ch2}, 8'h05);
    bus_start();
    write_byte(8'hA2, ack); write_byte(8'hF9, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    write_byte(8'hA3, ack);
    expect_read("R11 aborted data discarded", 8'h13, 1'b0);
    bus_stop();

    repeat (50) @(negedge clk);
    check("R8 scoreboard drained", 8'(exp_q.size()), 8'd0);
    summary();
    $finish;
  end

endmodule